// File: doc/BRIEF.md
# Sample-Queued Pulse-Width Modulator

This block is a pulse-width modulator that software drives through a small 32-bit register window. A 12-bit prescaler divides the input clock into counting ticks. A period counter runs from zero to the programmed period length, and a comparator sets the single output high while the count is below the active duty value. Duty values are not written straight into the comparator. Software pushes them into a four-entry sample queue, and the block pulls one entry at each period boundary. A stream of duty values therefore plays back one per period without software having to time its writes to the waveform.

The control word holds the run enable, a self-clearing soft reset, the prescaler field and a two-bit tick-source select. It also holds three permissions that decide whether counting continues while the debug, wait or doze input pins are high. The status word reports the queue fill level and a sticky overflow flag. The register port uses plain single-cycle read and write strobes. Every access completes in one cycle, so there is no back-pressure: a sample write that finds the queue full is dropped and recorded in the overflow flag.

Top module: `pwm_sampler`

## Requirements
- R1: Byte offsets decode as control 0x00, status 0x04, sample 0x0C and period 0x10. Read data is registered and appears on `reg_rdata` in the cycle after `reg_rd`. Any other offset reads zero. Control reads back enable in bit 0, soft reset in bit 3, prescaler in bits 15:4, source in bits 17:16 and the debug, wait and doze permissions in bits 22, 23 and 24.
- R2: Control bit 0 is the run enable. While it is 0 the counter holds and `pwm_out` is 0. A control write that changes it from 0 to 1 clears the count and the prescaler, and pops the oldest queued sample into the active duty in the same cycle.
- R3: Writing control with bit 3 set ignores the other bits of that write and sets a pending flag, which reads as 1 for one cycle. On the next edge every register, the queue and the active duty return to zero, and the flag clears itself.
- R4: With prescaler field P (bits 15:4), the period counter advances once every P+1 clock cycles while running.
- R5: Source field (bits 17:16) value 0 stops the counter. Values 1, 2 and 3 all let it count from the one input clock.
- R6: While `halt_dbg`, `halt_wait` or `halt_doze` is high and its control permission (bit 22, 23 or 24) is 0, the counter and prescaler hold. When the permission is 1, that input is ignored.
- R7: One period lasts min(period register, 0xFFFE) + 2 ticks. The register keeps and reads back the raw value written.
- R8: A sample write pushes its low 16 bits into a four-entry FIFO. Status bits 2:0 give the entry count, which is 4 when the FIFO is full.
- R9: A sample write while 4 entries are held is dropped and sets status bit 4. The flag stays set until a status write with bit 4 set clears it.
- R10: At each period boundary the oldest entry, if any, becomes the active duty. If the FIFO is empty, the previous duty is kept. A sample read returns the active duty.
- R11: `pwm_out` is high while the count is below the active duty. A duty of 0 keeps it low, and a duty at or above the period length keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| halt_dbg | input | 1 | Debug-state indication |
| halt_wait | input | 1 | Wait-state indication |
| halt_doze | input | 1 | Doze-state indication |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with its default parameters: 16-bit duty and period, a 12-bit prescaler and a four-entry queue. With a four-entry queue, overflow and drain are reached in a handful of writes. Short periods of five ticks let each queued duty be measured as an exact count of high cycles, and a prescaler of 3 shows the stretched period. The 16-bit period width still allows one full clamped period of 65536 cycles, which separates the clamp at 0xFFFE from a plain register value of 0xFFFF.

// File: rtl/pwm_sampler_pkg.sv
package pwm_sampler_pkg;
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_STATUS = 'h04;
  localparam int OFF_SAMPLE = 'h0C;
  localparam int OFF_PERIOD = 'h10;

  localparam int BIT_EN      = 0;
  localparam int BIT_SRST    = 3;
  localparam int LSB_PRE     = 4;
  localparam int LSB_SRC     = 16;
  localparam int BIT_DBG_OK  = 22;
  localparam int BIT_WAIT_OK = 23;
  localparam int BIT_DOZE_OK = 24;
  localparam int BIT_OVF     = 4;

  typedef struct packed {
    logic       doze_ok;
    logic       wait_ok;
    logic       dbg_ok;
    logic [1:0] src;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (count != CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;

  assign tick = run && (pcnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (clear)  pcnt <= '0;
    else if (run)    pcnt <= tick ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         enable,
  input  logic         tick,
  input  logic [W-1:0] period_reg,
  input  logic [W-1:0] duty,
  output logic [W:0]   cnt,
  output logic         rollover,
  output logic         pwm
);
  localparam int CW = W + 1;
  localparam logic [W-1:0] PER_MAX = {{(W-1){1'b1}}, 1'b0};

  logic [W-1:0] per_eff;
  logic [W:0]   last;

  always_comb begin
    per_eff = (period_reg > PER_MAX) ? PER_MAX : period_reg;
    last    = {1'b0, per_eff} + CW'(1);
  end

  assign rollover = enable && tick && (cnt >= last);
  assign pwm      = enable && (cnt < {1'b0, duty});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (rollover)         cnt <= '0;
    else if (enable && tick)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_sampler.sv
module pwm_sampler
  import pwm_sampler_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PRE_W      = 12,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              halt_dbg,
  input  logic              halt_wait,
  input  logic              halt_doze,
  output logic              pwm_out
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  ctrl_t             ctl_q;
  logic [PRE_W-1:0]  pre_q;
  logic [DATA_W-1:0] per_q, duty_q, fifo_dout;
  logic              srst_q, ovf_q;
  logic [CNT_W-1:0]  fill;
  logic [DATA_W:0]   cnt;
  logic              sel_ctrl, sel_stat, sel_smp, sel_per;
  logic              wr_ctrl, srst_req, ctl_load, start, smp_wr, fifo_full;
  logic              run, tick, rollover, pop, unused_wdata;
  logic [2:0]        halt_vec, allow_vec;
  logic [31:0]       rd_val;

  assign sel_ctrl = int'(reg_addr) == OFF_CTRL;
  assign sel_stat = int'(reg_addr) == OFF_STATUS;
  assign sel_smp  = int'(reg_addr) == OFF_SAMPLE;
  assign sel_per  = int'(reg_addr) == OFF_PERIOD;

  assign wr_ctrl  = reg_wr && sel_ctrl && !srst_q;
  assign srst_req = wr_ctrl && reg_wdata[BIT_SRST];
  assign ctl_load = wr_ctrl && !reg_wdata[BIT_SRST];
  assign start    = ctl_load && reg_wdata[BIT_EN] && !ctl_q.en;
  assign smp_wr   = reg_wr && sel_smp && !srst_q;
  assign fifo_full = fill == CNT_W'(FIFO_DEPTH);
  assign unused_wdata = ^reg_wdata;

  assign halt_vec  = {halt_doze, halt_wait, halt_dbg};
  assign allow_vec = {ctl_q.doze_ok, ctl_q.wait_ok, ctl_q.dbg_ok};
  assign run = ctl_q.en && (ctl_q.src != 2'd0) && !srst_q
               && ((halt_vec & ~allow_vec) == 3'b000);
  assign pop = (start || rollover) && (fill != '0);

  pwm_sample_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(srst_q),
    .push(smp_wr), .din(reg_wdata[DATA_W-1:0]),
    .pop(pop), .dout(fifo_dout), .count(fill)
  );

  pwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clear(srst_q || start),
    .run(run), .div(pre_q), .tick(tick)
  );

  pwm_period_core #(.W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clear(srst_q || start),
    .enable(ctl_q.en), .tick(tick), .period_reg(per_q), .duty(duty_q),
    .cnt(cnt), .rollover(rollover), .pwm(pwm_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      pre_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      ovf_q  <= 1'b0;
      srst_q <= 1'b0;
    end else if (srst_q) begin
      ctl_q  <= '0;
      pre_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      ovf_q  <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= srst_req;
      if (ctl_load) begin
        ctl_q.en      <= reg_wdata[BIT_EN];
        ctl_q.src     <= reg_wdata[LSB_SRC +: 2];
        ctl_q.dbg_ok  <= reg_wdata[BIT_DBG_OK];
        ctl_q.wait_ok <= reg_wdata[BIT_WAIT_OK];
        ctl_q.doze_ok <= reg_wdata[BIT_DOZE_OK];
        pre_q         <= reg_wdata[LSB_PRE +: PRE_W];
      end
      if (reg_wr && sel_per) per_q <= reg_wdata[DATA_W-1:0];
      if (pop) duty_q <= fifo_dout;
      if (smp_wr && fifo_full)                        ovf_q <= 1'b1;
      else if (reg_wr && sel_stat && reg_wdata[BIT_OVF]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel_ctrl) begin
      rd_val[BIT_EN]            = ctl_q.en;
      rd_val[BIT_SRST]          = srst_q;
      rd_val[LSB_PRE +: PRE_W]  = pre_q;
      rd_val[LSB_SRC +: 2]      = ctl_q.src;
      rd_val[BIT_DBG_OK]        = ctl_q.dbg_ok;
      rd_val[BIT_WAIT_OK]       = ctl_q.wait_ok;
      rd_val[BIT_DOZE_OK]       = ctl_q.doze_ok;
    end else if (sel_stat) begin
      rd_val[CNT_W-1:0] = fill;
      rd_val[BIT_OVF]   = ovf_q;
    end else if (sel_smp) begin
      rd_val[DATA_W-1:0] = duty_q;
    end else if (sel_per) begin
      rd_val[DATA_W-1:0] = per_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/pwm_sampler_chk.sv
module pwm_sampler_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       en,
  input logic [1:0]                 src,
  input logic                       wr_ctrl,
  input logic                       smp_wr,
  input logic                       srst,
  input logic                       ovf,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic [DATA_W-1:0]          duty,
  input logic [DATA_W:0]            cnt,
  input logic                       pwm_out
);
  // R2: output is low whenever the block is disabled
  a_r2_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);
  // R8: fill never exceeds the queue depth
  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));
  // R11: zero duty keeps the output low
  a_r11_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> !pwm_out);
  // R3: pending soft reset empties state on the next edge
  a_r3_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (fill == '0 && !en && duty == '0 && !srst && !ovf));
  // R9: a write into a full queue raises the sticky flag
  a_r9_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_wr && fill == ($clog2(DEPTH+1))'(DEPTH)) |=> ovf);
  // R5: source 0 freezes the count
  a_r5_nosrc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && src == 2'd0 && !wr_ctrl && !srst) |=> $stable(cnt));
endmodule

bind pwm_sampler pwm_sampler_chk #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .src(ctl_q.src),
  .wr_ctrl(wr_ctrl), .smp_wr(smp_wr), .srst(srst_q), .ovf(ovf_q),
  .fill(fill), .duty(duty_q), .cnt(cnt), .pwm_out(pwm_out)
);

// File: tb/pwm_sampler_test.sv
module pwm_sampler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        halt_dbg = 1'b0, halt_wait = 1'b0, halt_doze = 1'b0;
  logic        pwm_out;

  int checks = 0, errors = 0;
  bit started = 0, done = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  pwm_sampler uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .halt_dbg(halt_dbg), .halt_wait(halt_wait), .halt_doze(halt_doze),
    .pwm_out(pwm_out)
  );

  // behavioural reference model
  int m_en, m_src, m_dbg, m_wait, m_doze, m_pre, m_per, m_duty;
  int m_cnt, m_pcnt, m_ovf, m_srst;
  int q[$];
  logic [31:0] m_rdata;

  function automatic logic [31:0] mread(input int a);
    logic [31:0] v = '0;
    if (a == 'h00) v = m_en | (m_srst << 3) | (m_pre << 4) | (m_src << 16)
                       | (m_dbg << 22) | (m_wait << 23) | (m_doze << 24);
    else if (a == 'h04) v = q.size() | (m_ovf << 4);
    else if (a == 'h0C) v = m_duty;
    else if (a == 'h10) v = m_per;
    return v;
  endfunction

  task automatic mclear();
    m_en = 0; m_src = 0; m_dbg = 0; m_wait = 0; m_doze = 0; m_pre = 0;
    m_per = 0; m_duty = 0; m_cnt = 0; m_pcnt = 0; m_ovf = 0; m_srst = 0;
    q.delete();
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclear();
      m_rdata = '0;
    end else begin
      int a, len, n;
      bit wc, srq, cw, st, run, tk, ro, sw, full;
      a = int'(reg_addr);
      if (reg_rd) m_rdata = mread(a);
      if (m_srst != 0) begin
        mclear();
      end else begin
        wc  = reg_wr && a == 'h00;
        srq = wc && reg_wdata[3];
        cw  = wc && !reg_wdata[3];
        st  = cw && reg_wdata[0] && m_en == 0;
        run = m_en != 0 && m_src != 0 && !(halt_dbg && m_dbg == 0)
              && !(halt_wait && m_wait == 0) && !(halt_doze && m_doze == 0);
        tk  = run && m_pcnt == m_pre;
        len = ((m_per > 'hFFFE) ? 'hFFFE : m_per) + 2;
        ro  = m_en != 0 && tk && m_cnt >= len - 1;
        sw  = reg_wr && a == 'h0C;
        n   = q.size();
        full = n == 4;
        if ((st || ro) && n > 0) m_duty = q.pop_front();
        if (sw && !full) q.push_back(int'(reg_wdata[15:0]));
        if (sw && full) m_ovf = 1;
        else if (reg_wr && a == 'h04 && reg_wdata[4]) m_ovf = 0;
        if (st) begin
          m_cnt = 0; m_pcnt = 0;
        end else if (run) begin
          if (tk) begin
            m_pcnt = 0;
            m_cnt = ro ? 0 : m_cnt + 1;
          end else m_pcnt = (m_pcnt + 1) % 4096;
        end
        if (srq) m_srst = 1;
        if (cw) begin
          m_en = reg_wdata[0]; m_pre = int'(reg_wdata[15:4]);
          m_src = int'(reg_wdata[17:16]); m_dbg = reg_wdata[22];
          m_wait = reg_wdata[23]; m_doze = reg_wdata[24];
        end
        if (reg_wr && a == 'h10) m_per = int'(reg_wdata[15:0]);
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      logic m_pwm;
      m_pwm = (m_en != 0) && (m_cnt < m_duty);
      checks += 2;
      if (pwm_out !== m_pwm) begin
        errors++;
        $display("FAIL %s model pwm_out actual %0b expected %0b", cur_tag, pwm_out, m_pwm);
      end
      if (reg_rdata !== m_rdata) begin
        errors++;
        $display("FAIL %s model reg_rdata actual %h expected %h", cur_tag, reg_rdata, m_rdata);
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a[4:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string what);
    reg_rd = 1'b1; reg_addr = a[4:0];
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rdata === exp, what, int'(reg_rdata), int'(exp));
  endtask

  task automatic highs(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  task automatic soft_reset();
    wr('h00, 32'h8);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);

    cur_tag = "R1";
    rd_chk('h00, 0, "R1 ctrl after reset");
    rd_chk('h04, 0, "R1 status after reset");
    rd_chk('h0C, 0, "R1 sample after reset");
    rd_chk('h10, 0, "R1 period after reset");
    wr('h10, 32'h1234);
    rd_chk('h10, 32'h1234, "R1 period readback");
    rd_chk('h08, 0, "R1 unmapped offset");
    wr('h00, 32'h01C20050);
    rd_chk('h00, 32'h01C20050, "R1 ctrl field readback");

    cur_tag = "R3";
    wr('h0C, 7);
    wr('h00, 32'h8);
    rd_chk('h00, 32'h01C20058, "R3 reset flag visible");
    rd_chk('h00, 0, "R3 flag self-clears and ctrl zero");
    rd_chk('h04, 0, "R3 fifo flushed");
    rd_chk('h10, 0, "R3 period zero");

    cur_tag = "R8";
    wr('h0C, 2); wr('h0C, 5); wr('h0C, 0);
    rd_chk('h04, 3, "R8 fill three");
    cur_tag = "R9";
    wr('h0C, 9);
    rd_chk('h04, 4, "R9 full no flag");
    wr('h0C, 11);
    rd_chk('h04, 32'h14, "R9 overflow flag");
    wr('h04, 32'h10);
    rd_chk('h04, 4, "R9 flag cleared");
    cur_tag = "R10";
    rd_chk('h0C, 0, "R10 duty before enable");

    cur_tag = "R11";
    wr('h10, 3);
    wr('h00, 32'h10001);
    highs(5, h); chk(h == 2, "R11 duty 2 of 5", h, 2);
    highs(5, h); chk(h == 5, "R11 duty above period high", h, 5);
    highs(5, h); chk(h == 0, "R11 duty zero low", h, 0);
    highs(5, h); chk(h == 5, "R10 queued 9 popped", h, 5);
    cur_tag = "R10";
    highs(5, h); chk(h == 5, "R10 empty keeps duty", h, 5);
    rd_chk('h0C, 9, "R10 sample reads active duty");

    cur_tag = "R2";
    wr('h00, 0);
    highs(5, h); chk(h == 0, "R2 disabled low", h, 0);
    wr('h0C, 1);
    wr('h00, 32'h10001);
    highs(5, h); chk(h == 1, "R2 restart pops new duty", h, 1);

    cur_tag = "R4";
    soft_reset();
    wr('h10, 3); wr('h0C, 2);
    wr('h00, 32'h10021);
    highs(15, h); chk(h == 6, "R4 divide by 3", h, 6);

    cur_tag = "R5";
    soft_reset();
    wr('h10, 3); wr('h0C, 3);
    wr('h00, 32'h1);
    highs(20, h); chk(h == 20, "R5 source 0 frozen", h, 20);
    wr('h00, 32'h20001);
    highs(10, h); chk(h == 6, "R5 source 2 counts", h, 6);

    cur_tag = "R6";
    halt_dbg = 1'b1; @(negedge clk);
    highs(10, h); chk(h == 0 || h == 10, "R6 debug freeze", h, 0);
    wr('h00, 32'h420001);
    highs(10, h); chk(h == 6, "R6 debug permitted", h, 6);
    halt_dbg = 1'b0;
    wr('h00, 32'h20001);
    halt_wait = 1'b1; @(negedge clk);
    highs(10, h); chk(h == 0 || h == 10, "R6 wait freeze", h, 0);
    wr('h00, 32'h820001);
    highs(10, h); chk(h == 6, "R6 wait permitted", h, 6);
    halt_wait = 1'b0;
    wr('h00, 32'h20001);
    halt_doze = 1'b1; @(negedge clk);
    highs(10, h); chk(h == 0 || h == 10, "R6 doze freeze", h, 0);
    wr('h00, 32'h1020001);
    highs(10, h); chk(h == 6, "R6 doze permitted", h, 6);
    halt_doze = 1'b0;

    cur_tag = "R7";
    soft_reset();
    wr('h10, 32'hFFFF);
    wr('h0C, 32'hFFFF); wr('h0C, 1);
    wr('h00, 32'h10001);
    highs(65535, h); chk(h == 65535, "R7 long period high part", h, 65535);
    chk(pwm_out == 1'b0, "R7 last count low", int'(pwm_out), 0);
    @(negedge clk);
    chk(pwm_out == 1'b1, "R7 clamped period wraps", int'(pwm_out), 1);
    @(negedge clk);
    chk(pwm_out == 1'b0, "R7 next duty applied", int'(pwm_out), 0);
    rd_chk('h10, 32'hFFFF, "R7 raw period kept");

    done = 1;
    summary();
    $finish;
  end
endmodule